// File: doc/BRIEF.md
# LCD Raster Sync Timing Generator

This block turns a pixel clock into the raster timing of a parallel LCD panel. Two phase sequencers step through the four parts of a line and of a frame: sync, back porch, active and front porch. The horizontal sequencer advances on every pixel clock. The vertical sequencer advances once per line. From their positions the block drives four outputs: a horizontal sync, a vertical sync, a data-enable strobe and a panel-power strobe. It also reports the pixel position within the line and the line position within the frame.

Each strobe level can be inverted. Each edge of vertical sync can be placed either on the leading edge or on the trailing edge of horizontal sync. Panel power can come up at once, or it can wait for the end of the first horizontal sync pulse. All timing lengths and control bits are captured at the start of a frame. A change written part-way through a frame therefore takes effect only at the next frame. A zero length is treated as one cycle.

A small run machine sequences the block through three states:
- `ST_OFF`: idle, with the sequencers cleared.
- `ST_DARK`: scanning, with panel power still low.
- `ST_LIT`: scanning, with panel power high.

The machine has these transitions:
- `ST_OFF` goes to `ST_DARK` when `enable` is sampled high.
- `ST_DARK` goes to `ST_LIT` when the immediate-power bit is set, or when the first horizontal sync pulse ends.
- `ST_DARK` and `ST_LIT` both return to `ST_OFF` on the first edge at which `enable` is sampled low.

Each sequencer is itself a four-state machine with the states `PH_SYNC`, `PH_BACK`, `PH_ACTIVE` and `PH_FRONT`. It moves to the next state when the count for the current phase runs out, and goes from `PH_FRONT` back to `PH_SYNC`.

Top module: `lcd_raster_timer`

## Requirements
- R1: `hsync` is active for the programmed horizontal sync length at the start of every line. Its level is active-high when `cfg_word[0]` is 0 and active-low when it is 1.
- R2: `vsync` is active during the vertical sync lines of each frame. Its level is active-high when `cfg_word[1]` is 0 and active-low when it is 1.
- R3: The edge where `vsync` becomes active depends on `cfg_word[2]`. When the bit is 0, the edge falls at the trailing edge of `hsync` in the first sync line. When the bit is 1, it falls at the leading edge of `hsync` in that line.
- R4: The edge where `vsync` becomes inactive depends on `cfg_word[3]`. When the bit is 0, the edge falls at the trailing edge of `hsync` in the first back-porch line. When the bit is 1, it falls at the leading edge of `hsync` in that line.
- R5: `data_en` is active only while both the pixel and the line position are inside their active regions. Its level is active-high when `cfg_word[4]` is 0 and active-low when it is 1.
- R6: The rise of `panel_pwr` depends on `cfg_word[5]`.
  - When the bit is 0, `panel_pwr` rises on the same clock edge on which the first `hsync` pulse ends.
  - When the bit is 1, it rises on the first edge after the edge that samples `enable` high.
  - In both cases it then stays high until `enable` is low.
- R7: After reset, and from the first edge that samples `enable` low, these values hold:
  - `hsync`, `vsync` and `data_en` sit at their inactive levels.
  - `panel_pwr` is 0.
  - `h_pos` and `v_pos` are both 0.
- R8: The control bits and the lengths are captured at the start of each frame. A change made during a frame does not alter that frame.
- R9: `h_pos` counts from 0 at the start of a line up to the line total minus one, and then wraps to 0. `v_pos` advances by one per line and wraps at the frame total. A programmed length of 0 acts as a length of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Global run enable |
| cfg_word | input | 6 | Bit 0 inverts hsync, bit 1 inverts vsync, bit 2 selects the vsync start alignment, bit 3 selects the vsync end alignment, bit 4 inverts data_en, bit 5 selects immediate power |
| h_sync_len | input | CW | Horizontal sync length in pixels |
| h_back_len | input | CW | Horizontal back porch in pixels |
| h_active_len | input | CW | Active pixels per line |
| h_front_len | input | CW | Horizontal front porch in pixels |
| v_sync_len | input | CW | Vertical sync length in lines |
| v_back_len | input | CW | Vertical back porch in lines |
| v_active_len | input | CW | Active lines per frame |
| v_front_len | input | CW | Vertical front porch in lines |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| data_en | output | 1 | Data-enable strobe |
| panel_pwr | output | 1 | Panel power strobe, active high |
| h_pos | output | CW+2 | Pixel position within the line |
| v_pos | output | CW+2 | Line position within the frame |

## Verification
The hardest situation to reach is a control change that lands in the middle of a frame. For R8, the new polarity must stay invisible for the rest of that frame and must appear exactly at the wrap into the next frame. The stimulus starts a frame with one control word and rewrites `cfg_word` part-way through. It then samples `hsync` once inside the old frame and twice after the wrap, at positions worked out from the programmed totals. The vertical-sync alignment corners are reached in a similar way. The bench restarts the raster and samples at the exact pixels that border each `hsync` edge in the first sync line and in the first back-porch line.

// File: rtl/lcd_raster_pkg.sv
package lcd_raster_pkg;

    localparam int CTL_W = 6;

    // Phase of a line or a frame, in scan order.
    typedef enum logic [1:0] {
        PH_SYNC   = 2'd0,
        PH_BACK   = 2'd1,
        PH_ACTIVE = 2'd2,
        PH_FRONT  = 2'd3
    } phase_e;

    // Run machine states.
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_DARK = 2'd1,
        ST_LIT  = 2'd2
    } run_e;

    // The control word; the last member is bit 0.
    typedef struct packed {
        logic pwr_now;
        logic de_low;
        logic vs_end_lead;
        logic vs_start_lead;
        logic vs_low;
        logic hs_low;
    } ctl_t;

endpackage

// File: rtl/lcd_phase_seq.sv
module lcd_phase_seq
    import lcd_raster_pkg::*;
#(
    parameter int CW = 12,
    localparam int PW = CW + 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic                step,
    input  logic [3:0][CW-1:0]  lens,
    output phase_e              phase,
    output logic [CW-1:0]       cnt,
    output logic [PW-1:0]       pos,
    output logic                wrap
);

    phase_e        phase_n;
    logic [CW-1:0] cur_len;
    logic          at_end;

    // A zero length behaves as a single cycle.
    always_comb begin
        cur_len = lens[phase];
        if (cur_len == '0) begin
            cur_len = CW'(1);
        end
        at_end = (cnt == cur_len - CW'(1));
        wrap   = step && at_end && (phase == PH_FRONT);
    end

    always_comb begin
        phase_n = phase;
        if (at_end) begin
            unique case (phase)
                PH_SYNC:   phase_n = PH_BACK;
                PH_BACK:   phase_n = PH_ACTIVE;
                PH_ACTIVE: phase_n = PH_FRONT;
                PH_FRONT:  phase_n = PH_SYNC;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= PH_SYNC;
            cnt   <= '0;
            pos   <= '0;
        end else if (!run) begin
            phase <= PH_SYNC;
            cnt   <= '0;
            pos   <= '0;
        end else if (step) begin
            phase <= phase_n;
            cnt   <= at_end ? '0 : cnt + CW'(1);
            pos   <= wrap ? '0 : pos + PW'(1);
        end
    end

endmodule

// File: rtl/lcd_raster_timer.sv
module lcd_raster_timer
    import lcd_raster_pkg::*;
#(
    parameter int CW = 12,
    localparam int PW = CW + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CTL_W-1:0] cfg_word,
    input  logic [CW-1:0]    h_sync_len,
    input  logic [CW-1:0]    h_back_len,
    input  logic [CW-1:0]    h_active_len,
    input  logic [CW-1:0]    h_front_len,
    input  logic [CW-1:0]    v_sync_len,
    input  logic [CW-1:0]    v_back_len,
    input  logic [CW-1:0]    v_active_len,
    input  logic [CW-1:0]    v_front_len,
    output logic             hsync,
    output logic             vsync,
    output logic             data_en,
    output logic             panel_pwr,
    output logic [PW-1:0]    h_pos,
    output logic [PW-1:0]    v_pos
);

    localparam int NPOL = 3;

    run_e               state, state_n;
    logic               running;
    ctl_t               sh_ctl;
    logic [3:0][CW-1:0] sh_h, sh_v;
    logic [3:0][CW-1:0] in_h, in_v;

    phase_e             h_phase, v_phase;
    logic [CW-1:0]      h_cnt, v_cnt;
    logic [PW-1:0]      h_pos_c, v_pos_c;
    logic               h_wrap, v_wrap, frame_end;

    logic               hs_raw, vs_raw, de_raw, hs_trail;
    logic               hs_act_q, vs_act_q, de_act_q;
    logic [NPOL-1:0]    pol_n, pol_q;
    logic [NPOL-1:0]    act_q;

    assign in_h = {h_front_len, h_active_len, h_back_len, h_sync_len};
    assign in_v = {v_front_len, v_active_len, v_back_len, v_sync_len};

    assign running   = (state != ST_OFF) && enable;
    assign frame_end = h_wrap && v_wrap;

    // Capture the frame settings while idle and at every frame boundary.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_ctl <= '0;
            sh_h   <= '0;
            sh_v   <= '0;
        end else if (!running || frame_end) begin
            sh_ctl <= ctl_t'(cfg_word);
            sh_h   <= in_h;
            sh_v   <= in_v;
        end
    end

    lcd_phase_seq #(.CW(CW)) u_hseq (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (running),
        .step  (1'b1),
        .lens  (sh_h),
        .phase (h_phase),
        .cnt   (h_cnt),
        .pos   (h_pos_c),
        .wrap  (h_wrap)
    );

    lcd_phase_seq #(.CW(CW)) u_vseq (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (running),
        .step  (h_wrap),
        .lens  (sh_v),
        .phase (v_phase),
        .cnt   (v_cnt),
        .pos   (v_pos_c),
        .wrap  (v_wrap)
    );

    // Raw strobe decode from the sequencer positions.
    always_comb begin
        hs_raw   = (h_phase == PH_SYNC);
        hs_trail = (h_phase == PH_BACK) && (h_cnt == '0);
        de_raw   = (h_phase == PH_ACTIVE) && (v_phase == PH_ACTIVE);
        vs_raw   = ((v_phase == PH_SYNC) &&
                    (sh_ctl.vs_start_lead || !((v_cnt == '0) && hs_raw))) ||
                   (!sh_ctl.vs_end_lead && (v_phase == PH_BACK) &&
                    (v_cnt == '0) && hs_raw);
    end

    // Run machine: next state.
    always_comb begin
        state_n = state;
        unique case (state)
            ST_OFF:  if (enable) state_n = ST_DARK;
            ST_DARK: begin
                if (!enable) begin
                    state_n = ST_OFF;
                end else if (sh_ctl.pwr_now || hs_trail) begin
                    state_n = ST_LIT;
                end
            end
            ST_LIT:  if (!enable) state_n = ST_OFF;
            default: state_n = ST_OFF;
        endcase
    end

    // Run machine: state register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
        end else begin
            state <= state_n;
        end
    end

    // Polarity used with the strobes registered on the same edge.
    always_comb begin
        if (running) begin
            pol_n = {sh_ctl.de_low, sh_ctl.vs_low, sh_ctl.hs_low};
        end else begin
            pol_n = {cfg_word[4], cfg_word[1], cfg_word[0]};
        end
    end

    // Output registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_act_q <= 1'b0;
            vs_act_q <= 1'b0;
            de_act_q <= 1'b0;
            pol_q    <= '0;
            h_pos    <= '0;
            v_pos    <= '0;
        end else begin
            hs_act_q <= running && hs_raw;
            vs_act_q <= running && vs_raw;
            de_act_q <= running && de_raw;
            pol_q    <= pol_n;
            h_pos    <= running ? h_pos_c : '0;
            v_pos    <= running ? v_pos_c : '0;
        end
    end

    assign act_q = {de_act_q, vs_act_q, hs_act_q};

    logic [NPOL-1:0] pin_q;
    for (genvar g = 0; g < NPOL; g++) begin : g_pol
        assign pin_q[g] = act_q[g] ^ pol_q[g];
    end

    assign hsync     = pin_q[0];
    assign vsync     = pin_q[1];
    assign data_en   = pin_q[2];
    assign panel_pwr = (state == ST_LIT);

endmodule

// File: rtl/lcd_raster_checker.sv
module lcd_raster_checker #(
    parameter int CW = 12,
    parameter int PW = CW + 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          enable,
    input logic          hs_act,
    input logic          vs_act,
    input logic          de_act,
    input logic          pwr,
    input logic          pwr_now,
    input logic [CW-1:0] hs_len,
    input logic [PW-1:0] h_pos,
    input logic [PW-1:0] v_pos
);

    logic [PW-1:0] hs_eff;
    always_comb begin
        hs_eff = (hs_len == '0) ? PW'(1) : PW'(hs_len);
    end

    a_r7_idle_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!hs_act && !vs_act && !de_act && !pwr &&
                     h_pos == '0 && v_pos == '0));

    a_r5_de_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        de_act |-> (!hs_act && !vs_act));

    a_r6_pwr_on_trailing: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pwr) && !pwr_now) |-> $fell(hs_act));

    a_r6_pwr_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr && enable) |=> pwr);

    a_r3_vs_rise_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vs_act) |-> (h_pos == '0 || h_pos == hs_eff));

endmodule

bind lcd_raster_timer lcd_raster_checker #(.CW(CW), .PW(PW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .hs_act  (hs_act_q),
    .vs_act  (vs_act_q),
    .de_act  (de_act_q),
    .pwr     (panel_pwr),
    .pwr_now (sh_ctl.pwr_now),
    .hs_len  (sh_h[0]),
    .h_pos   (h_pos),
    .v_pos   (v_pos)
);

// File: tb/lcd_raster_timer_bench.sv
`timescale 1ns/1ps
module lcd_raster_timer_bench;

    localparam int CW = 12;
    localparam int PW = CW + 2;
    localparam int NVEC = 20;

    // Each entry: {control word, clock edges after the enabling edge}.
    localparam logic [13:0] VEC [NVEC] = '{
        {6'h00, 8'd1},  {6'h00, 8'd3},  {6'h00, 8'd5},  {6'h00, 8'd35},
        {6'h00, 8'd71}, {6'h01, 8'd1},  {6'h01, 8'd2},  {6'h02, 8'd1},
        {6'h04, 8'd1},  {6'h04, 8'd3},  {6'h08, 8'd21}, {6'h08, 8'd22},
        {6'h00, 8'd21}, {6'h00, 8'd23}, {6'h10, 8'd35}, {6'h10, 8'd36},
        {6'h20, 8'd1},  {6'h00, 8'd2},  {6'h00, 8'd3},  {6'h3F, 8'd35}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic [5:0]    cfg_word = '0;
    logic [CW-1:0] h_sync_len, h_back_len, h_active_len, h_front_len;
    logic [CW-1:0] v_sync_len, v_back_len, v_active_len, v_front_len;
    logic          hsync, vsync, data_en, panel_pwr;
    logic [PW-1:0] h_pos, v_pos;

    int checks = 0;
    int errors = 0;
    int kcur = 0;
    bit done = 0;

    always #4 clk = ~clk;

    lcd_raster_timer #(.CW(CW)) u_lcd_raster_timer (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_word(cfg_word),
        .h_sync_len(h_sync_len), .h_back_len(h_back_len),
        .h_active_len(h_active_len), .h_front_len(h_front_len),
        .v_sync_len(v_sync_len), .v_back_len(v_back_len),
        .v_active_len(v_active_len), .v_front_len(v_front_len),
        .hsync(hsync), .vsync(vsync), .data_en(data_en),
        .panel_pwr(panel_pwr), .h_pos(h_pos), .v_pos(v_pos)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (k=%0d)", what, act, exp, kcur);
        end
    endtask

    function automatic int eff(input logic [CW-1:0] v);
        return (v == '0) ? 1 : int'(v);
    endfunction

    // Reference model: position p counts pixel clocks since the raster began.
    task automatic check_point(input logic [5:0] c, input int p);
        int hs_l, hb_l, ha_l, hf_l, vs_l, vb_l, va_l, vf_l;
        int ht, ft, f, hp, ln, vs_s, vs_e;
        logic e_hs, e_vs, e_de, e_pw;
        hs_l = eff(h_sync_len); hb_l = eff(h_back_len);
        ha_l = eff(h_active_len); hf_l = eff(h_front_len);
        vs_l = eff(v_sync_len); vb_l = eff(v_back_len);
        va_l = eff(v_active_len); vf_l = eff(v_front_len);
        ht = hs_l + hb_l + ha_l + hf_l;
        ft = ht * (vs_l + vb_l + va_l + vf_l);
        f  = p % ft;
        hp = f % ht;
        ln = f / ht;
        e_hs = (hp < hs_l);
        vs_s = c[2] ? 0 : hs_l;
        vs_e = vs_l * ht + (c[3] ? 0 : hs_l);
        e_vs = (f >= vs_s) && (f < vs_e);
        e_de = (hp >= hs_l + hb_l) && (hp < hs_l + hb_l + ha_l) &&
               (ln >= vs_l + vb_l) && (ln < vs_l + vb_l + va_l);
        e_pw = c[5] || (p >= hs_l);
        chk("R1 hsync", 32'(hsync), 32'(e_hs ^ c[0]));
        chk("R2 R3 R4 vsync", 32'(vsync), 32'(e_vs ^ c[1]));
        chk("R5 data_en", 32'(data_en), 32'(e_de ^ c[4]));
        chk("R6 panel_pwr", 32'(panel_pwr), 32'(e_pw));
        chk("R9 h_pos", 32'(h_pos), 32'(hp));
        chk("R9 v_pos", 32'(v_pos), 32'(ln));
    endtask

    // Restart the raster with control word c and stop at the negedge after edge k.
    task automatic run_to(input logic [5:0] c, input int k);
        @(negedge clk);
        enable = 1'b0;
        cfg_word = c;
        repeat (2) @(negedge clk);
        enable = 1'b1;
        repeat (k + 1) @(posedge clk);
        @(negedge clk);
        kcur = k;
    endtask

    task automatic advance(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
        kcur += n;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        h_sync_len = 2; h_back_len = 2; h_active_len = 4; h_front_len = 2;
        v_sync_len = 2; v_back_len = 1; v_active_len = 3; v_front_len = 1;

        // R7: reset state
        repeat (3) @(negedge clk);
        chk("R7 reset hsync", 32'(hsync), 0);
        chk("R7 reset vsync", 32'(vsync), 0);
        chk("R7 reset data_en", 32'(data_en), 0);
        chk("R7 reset panel_pwr", 32'(panel_pwr), 0);
        chk("R7 reset h_pos", 32'(h_pos), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Table walk (R1..R6, R9)
        for (int i = 0; i < NVEC; i++) begin
            run_to(VEC[i][13:8], int'(VEC[i][7:0]));
            check_point(VEC[i][13:8], kcur - 1);
        end

        // R8: hsync polarity written mid-frame waits for the next frame
        run_to(6'h00, 20);
        cfg_word = 6'h01;
        advance(11);
        check_point(6'h00, kcur - 1);
        advance(40);
        check_point(6'h01, kcur - 1);
        advance(2);
        check_point(6'h01, kcur - 1);

        // R7: disable mid-frame with inverted strobes
        run_to(6'h13, 35);
        enable = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R7 off hsync", 32'(hsync), 1);
        chk("R7 off vsync", 32'(vsync), 1);
        chk("R7 off data_en", 32'(data_en), 1);
        chk("R7 off panel_pwr", 32'(panel_pwr), 0);
        chk("R7 off h_pos", 32'(h_pos), 0);
        chk("R7 off v_pos", 32'(v_pos), 0);

        // R9: zero front porch acts as one pixel
        h_front_len = 0;
        run_to(6'h00, 10);
        chk("R9 zero-length wrap h_pos", 32'(h_pos), 0);
        chk("R9 zero-length wrap v_pos", 32'(v_pos), 1);
        run_to(6'h00, 9);
        check_point(6'h00, kcur - 1);
        h_front_len = 2;

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule